// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device side of a small serial EEPROM. It holds 64 words of 16 bits. A host talks to it over three wires: chip select, serial clock and data in. The block answers on one data-out wire, which has its own output enable. The three inputs are resynchronised into the system clock domain. Each instruction is shifted in MSB first on rising serial-clock edges and is decoded inside the block.

Seven operations are available. Read works at any time. Two operations set and clear a write-enable latch. Four operations change the array, and each of them is honoured only while that latch is set. Every array change runs a timed programming cycle, whose length is a parameter counted in system clocks, and the store happens when that cycle ends. While the cycle runs, the host can lower chip select for at least a minimum time and then raise it again. Data-out then reports busy as 0 and ready as 1.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low and the write-enable latch is clear, so a write sent before any enable instruction leaves memory unchanged.
- R2: Once chip select is high, zeros sampled on data-in are skipped. The first 1 is the start bit, and the 2-bit opcode and then the 6-bit address follow it, MSB first.
- R3: Read (opcode 10) drives a 0 on data-out with the output enable high, starting from the rising clock edge that carries the last address bit. Each of the next 16 rising edges then presents the word, MSB first.
- R4: Write (opcode 01), sent while the latch is set, stores the 16 data bits that follow the address, MSB first.
- R5: Opcode 00 with address bits [5:4] = 11 sets the latch, and with [5:4] = 00 clears it. While the latch is clear, write, erase, erase-all and write-all have no effect.
- R6: Read returns stored data whether the latch is set or clear.
- R7: Erase (opcode 11) sets the addressed word to FFFF and leaves every other word as it was.
- R8: Opcode 00 with [5:4] = 10 sets every word to FFFF. Opcode 00 with [5:4] = 01 writes the 16-bit pattern that follows into every word.
- R9: After an array-changing instruction, chip select can be held low for at least CS_MIN_CLKS clocks and then raised while the cycle is still running. Data-out is then enabled and reads 0, and it turns to 1 when the cycle ends, until chip select falls.
- R10: No status is shown if chip select rises after the cycle has ended, or if the low time before that rise was shorter than CS_MIN_CLKS.
- R11: A start bit that arrives while a programming cycle is running is ignored.
- R12: Dropping chip select in the middle of an instruction aborts it with no effect.
- R13: The output enable is low whenever the block is neither shifting out read data nor showing status, and it drops within two clocks after chip select is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from the host, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial read data or busy/ready flag |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
A bad write-enable latch or a bad programming timer shows up at the ports as a word that is written or left alone when it should not be. That error appears at the next read of the word, about 26 serial-clock periods later. A fault in the command shifter or the read shifter corrupts the dummy bit or a data bit in the very next read. The bench writes every address with its own pattern and reads each one back, so a single bad address bit is caught. A bad status window shows on the output enable within a few clocks of the chip-select rise.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CLKS   = 200,
  parameter int CS_MIN_CLKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CMDW  = ADDR_W + 2;
  localparam int NW    = $clog2(DATA_W + 1);
  localparam int CW    = $clog2(PROG_CLKS + 1);
  localparam int LW    = $clog2(CS_MIN_CLKS + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_CMD = 3'd1, S_DATA = 3'd2,
                         S_RD = 3'd3, S_WAIT = 3'd4, S_STAT = 3'd5;

  logic [2:0] cs_sy, sk_sy;
  logic [1:0] di_sy;
  logic cs_s, cs_rise, sk_rise, di_s;
  logic [2:0] st_q;
  logic [NW-1:0] cnt_q;
  logic [CMDW-2:0] cmd_q;
  logic [CMDW-1:0] cmd_nx;
  logic [1:0] opc;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic op_all, wen, busy, arm, oe_q, dq;
  logic [CW-1:0] bcnt;
  logic [LW-1:0] lowcnt;
  logic commit, rd_on, stat_on, cmd_on;

  assign cs_s    = cs_sy[1];
  assign cs_rise = cs_sy[1] & ~cs_sy[2];
  assign sk_rise = sk_sy[1] & ~sk_sy[2];
  assign di_s    = di_sy[1];
  assign cmd_nx  = {cmd_q, di_s};
  assign opc     = cmd_nx[CMDW-1:CMDW-2];
  assign adr     = cmd_nx[ADDR_W-1:0];
  assign commit  = busy && (bcnt == '0);
  assign rd_on   = (st_q == S_RD);
  assign stat_on = (st_q == S_STAT);
  assign cmd_on  = (st_q == S_CMD);
  assign do_o    = stat_on ? ~busy : dq;
  assign do_oe_o = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '0; sk_sy <= '0; di_sy <= '0;
    end else begin
      cs_sy <= {cs_sy[1:0], cs_i};
      sk_sy <= {sk_sy[1:0], sk_i};
      di_sy <= {di_sy[0], di_i};
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (op_all) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= op_data;
      end else begin
        mem[op_addr] <= op_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; cmd_q <= '0; sh_q <= '0;
      op_addr <= '0; op_data <= '0; op_all <= 1'b0;
      wen <= 1'b0; busy <= 1'b0; arm <= 1'b0; oe_q <= 1'b0; dq <= 1'b0;
      bcnt <= '0; lowcnt <= '0;
    end else begin
      if (commit) busy <= 1'b0;
      else if (busy) bcnt <= bcnt - 1'b1;

      if (!cs_s) begin
        st_q <= S_IDLE;
        oe_q <= 1'b0;
        if (lowcnt != LW'(CS_MIN_CLKS)) lowcnt <= lowcnt + 1'b1;
      end else begin
        lowcnt <= '0;
        if (cs_rise) begin
          arm <= 1'b0;
          if (arm && busy && lowcnt >= LW'(CS_MIN_CLKS)) begin
            st_q <= S_STAT;
            oe_q <= 1'b1;
          end
        end else if (sk_rise) begin
          case (st_q)
            S_IDLE, S_STAT: begin
              if (di_s && !busy) begin
                st_q  <= S_CMD;
                cnt_q <= '0;
                oe_q  <= 1'b0;
              end
            end
            S_CMD: begin
              cmd_q <= cmd_nx[CMDW-2:0];
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == NW'(CMDW - 1)) begin
                cnt_q <= '0;
                st_q  <= S_WAIT;
                case (opc)
                  2'b10: begin
                    sh_q <= mem[adr];
                    dq   <= 1'b0;
                    oe_q <= 1'b1;
                    st_q <= S_RD;
                  end
                  2'b01: begin
                    op_all  <= 1'b0;
                    op_addr <= adr;
                    st_q    <= S_DATA;
                  end
                  2'b11: begin
                    if (wen) begin
                      busy <= 1'b1; bcnt <= CW'(PROG_CLKS - 1); arm <= 1'b1;
                      op_all <= 1'b0; op_addr <= adr; op_data <= '1;
                    end
                  end
                  default: begin
                    case (adr[ADDR_W-1:ADDR_W-2])
                      2'b11: wen <= 1'b1;
                      2'b00: wen <= 1'b0;
                      2'b10: begin
                        if (wen) begin
                          busy <= 1'b1; bcnt <= CW'(PROG_CLKS - 1); arm <= 1'b1;
                          op_all <= 1'b1; op_data <= '1;
                        end
                      end
                      default: begin
                        op_all <= 1'b1;
                        st_q   <= S_DATA;
                      end
                    endcase
                  end
                endcase
              end
            end
            S_DATA: begin
              sh_q  <= {sh_q[DATA_W-2:0], di_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == NW'(DATA_W - 1)) begin
                st_q <= S_WAIT;
                if (wen) begin
                  busy <= 1'b1; bcnt <= CW'(PROG_CLKS - 1); arm <= 1'b1;
                  op_data <= {sh_q[DATA_W-2:0], di_s};
                end
              end
            end
            S_RD: begin
              if (cnt_q == NW'(DATA_W)) begin
                oe_q <= 1'b0;
                st_q <= S_WAIT;
              end else begin
                dq    <= sh_q[DATA_W-1];
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module mw_eeprom_chk #(
  parameter int PROG_CLKS = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic busy,
  input logic wen,
  input logic do_oe_o,
  input logic rd_on,
  input logic stat_on,
  input logic cmd_on,
  input logic [$clog2(PROG_CLKS+1)-1:0] bcnt
);
  localparam int CW = $clog2(PROG_CLKS + 1);

  p_oe_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe_o);
  p_oe_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe_o |-> (rd_on || stat_on));
  p_prog_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  p_wen_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen) |-> $past(cmd_on));
  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_on) |=> !rd_on);
  p_timer_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < CW'(PROG_CLKS)));
  p_status_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_on) |-> $past(busy));
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CLKS(PROG_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy), .wen(wen),
  .do_oe_o(do_oe_o), .rd_on(rd_on), .stat_on(stat_on), .cmd_on(cmd_on),
  .bcnt(bcnt)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb_top;
  localparam int PROG  = 200;
  localparam int CSMIN = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe_o;
  int checks = 0;
  int fails = 0;
  logic [15:0] shadow [64];

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(6), .DATA_W(16), .PROG_CLKS(PROG), .CS_MIN_CLKS(CSMIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_oe_o(do_oe_o)
  );

  task automatic clk_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503 + 16'h1F0E) ^ (a << 10));
  endfunction

  task automatic send_bit(logic b);
    di = b; clk_wait(4);
    sk = 1'b1; clk_wait(4);
    sk = 1'b0; clk_wait(2);
  endtask

  task automatic begin_cmd();
    cs = 1'b1; clk_wait(4);
  endtask

  task automatic end_cmd();
    cs = 1'b0; di = 1'b0; clk_wait(30);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [5:0] a);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 5; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic wr_bits(int a, logic [15:0] d);
    begin_cmd();
    send_cmd(2'b01, 6'(a));
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic wr(int a, logic [15:0] d);
    wr_bits(a, d);
    end_cmd();
    clk_wait(PROG + 10);
  endtask

  task automatic special(logic [1:0] sel, bit follow, logic [15:0] d);
    begin_cmd();
    send_cmd(2'b00, {sel, 4'b0000});
    if (follow) for (int i = 15; i >= 0; i--) send_bit(d[i]);
    end_cmd();
    clk_wait(PROG + 10);
  endtask

  task automatic erase(int a);
    begin_cmd();
    send_cmd(2'b11, 6'(a));
    end_cmd();
    clk_wait(PROG + 10);
  endtask

  task automatic rd_chk(int a, logic [15:0] exp, string r, int lead0);
    logic [15:0] got;
    got = '0;
    begin_cmd();
    for (int i = 0; i < lead0; i++) send_bit(1'b0);
    send_cmd(2'b10, 6'(a));
    chk({r, " R3 dummy"}, {30'd0, do_oe_o, do_o}, 32'd2);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0);
      got[i] = do_o;
    end
    end_cmd();
    chk($sformatf("%s read addr %0d", r, a), {16'd0, got}, {16'd0, exp});
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clk_wait(5);
    rst_n = 1'b1;
    clk_wait(5);
    chk("R1 oe after reset", {31'd0, do_oe_o}, 32'd0);
    chk("R13 oe idle", {31'd0, do_oe_o}, 32'd0);

    special(2'b11, 0, '0);
    special(2'b10, 0, '0);
    for (int a = 0; a < 64; a++) shadow[a] = 16'hFFFF;

    rst_n = 1'b0; clk_wait(5); rst_n = 1'b1; clk_wait(5);
    wr(5, 16'h1234);
    rd_chk(5, shadow[5], "R1 latch clear after reset", 0);

    special(2'b11, 0, '0);
    for (int a = 0; a < 64; a++) begin
      wr(a, pat(a));
      shadow[a] = pat(a);
    end
    for (int a = 0; a < 64; a++) rd_chk(a, shadow[a], "R4", 0);

    rd_chk(33, shadow[33], "R2 leading zeros", 3);

    erase(7);
    shadow[7] = 16'hFFFF;
    rd_chk(7, shadow[7], "R7 erased", 0);
    rd_chk(6, shadow[6], "R7 neighbour", 0);
    rd_chk(8, shadow[8], "R7 neighbour", 0);

    special(2'b00, 0, '0);
    wr(3, 16'h0F0F);
    erase(4);
    special(2'b01, 1, 16'h5A5A);
    special(2'b10, 0, '0);
    rd_chk(3, shadow[3], "R5 write blocked R6", 0);
    rd_chk(4, shadow[4], "R5 erase blocked R6", 0);
    rd_chk(10, shadow[10], "R5 all-ops blocked R6", 0);

    special(2'b11, 0, '0);
    begin_cmd();
    send_cmd(2'b01, 6'd9);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    end_cmd();
    clk_wait(PROG + 10);
    rd_chk(9, shadow[9], "R12 abort", 0);

    wr_bits(11, 16'hBEEF);
    cs = 1'b0; di = 1'b0; clk_wait(30);
    cs = 1'b1; clk_wait(6);
    chk("R9 busy flag", {30'd0, do_oe_o, do_o}, 32'd2);
    clk_wait(PROG);
    chk("R9 ready flag", {30'd0, do_oe_o, do_o}, 32'd3);
    cs = 1'b0; clk_wait(6);
    chk("R13 oe after status", {31'd0, do_oe_o}, 32'd0);
    clk_wait(20);
    shadow[11] = 16'hBEEF;
    rd_chk(11, shadow[11], "R9 data stored", 0);

    wr_bits(12, 16'h1357);
    cs = 1'b0; di = 1'b0; clk_wait(10);
    cs = 1'b1; clk_wait(6);
    chk("R10 short low no status", {31'd0, do_oe_o}, 32'd0);
    cs = 1'b0; clk_wait(PROG + 20);
    shadow[12] = 16'h1357;
    rd_chk(12, shadow[12], "R10 data stored", 0);

    wr_bits(13, 16'h2468);
    cs = 1'b0; di = 1'b0; clk_wait(PROG + 20);
    cs = 1'b1; clk_wait(6);
    chk("R10 late rise no status", {31'd0, do_oe_o}, 32'd0);
    cs = 1'b0; clk_wait(10);
    shadow[13] = 16'h2468;

    wr_bits(14, 16'hC0DE);
    cs = 1'b0; di = 1'b0; clk_wait(10);
    cs = 1'b1; clk_wait(4);
    send_cmd(2'b10, 6'd14);
    chk("R11 read ignored while busy", {31'd0, do_oe_o}, 32'd0);
    cs = 1'b0; di = 1'b0; clk_wait(PROG);
    shadow[14] = 16'hC0DE;
    rd_chk(14, shadow[14], "R11 data stored", 0);

    special(2'b01, 1, 16'hA5C3);
    for (int a = 0; a < 64; a++) rd_chk(a, 16'hA5C3, "R8 write-all", 0);
    special(2'b10, 0, '0);
    for (int a = 0; a < 64; a++) rd_chk(a, 16'hFFFF, "R8 erase-all", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule